// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator

This block watches the seven timekeeping fields of a real-time clock (seconds, minutes, hours, date, month, day of week, year). An external counter supplies these fields. The block compares them against seven programmable threshold registers. A configuration register selects which fields must agree. When every selected field equals its threshold at the same time, the block raises an alarm and holds it. An active-low pin and a status flag both carry the alarm.

Software reaches the thresholds and the configuration through a small register bus. The bus has an address, a write strobe, a read strobe, write data and registered read data. The same bus also reads back the current time fields. In the minutes readback, the top bit is replaced by the alarm state, so firmware can poll the alarm instead of wiring the pin.

The alarm stays held until software touches any alarm register, by reading or by writing it. The block detects the start of a match, not the match level. After the alarm is cleared, a match that continues to hold does not fire again. The fields must first move away from the thresholds and then come back.

Top module: `rtc_alarm_top`

## Requirements
- R1: Configuration bits 0..6 enable comparison of seconds, minutes, hours, date, month, day and year respectively (field index 0..6). Bit 7 has no effect and always reads back as 0.
- R2: When the configuration is nonzero and every enabled field equals its threshold, the alarm is set on the clock edge at which that condition is first seen. On that edge `alarm_n` goes to 0 and `alarm_flag` goes to 1.
- R3: With a configuration value of 0 the alarm never sets, whatever the time and threshold values are.
- R4: The alarm sets only when the qualified match goes from false to true. If the match is still true after a clear, the alarm stays clear until the match drops and rises again.
- R5: Once set, the alarm holds until an access clears it on that edge. An access is a read or write strobe at any address from 0x80 to 0x8D, or at 0x94 or 0x95. Strobes at any other address, including time readbacks, leave it set.
- R6: If a new match start and a clearing access happen on the same edge, the alarm ends up set.
- R7: Threshold i is written at address 0x80+2i and read at 0x81+2i. The configuration is written at 0x94 and read at 0x95.
- R8: Read data appears one cycle after the read strobe and is 0 in every cycle without a read strobe. A read of an unmapped address returns 0.
- R9: Time field i reads at address 0xA1+2i. For minutes (0xA3), bit 7 is replaced by the alarm state, 1 meaning triggered. That read does not clear the alarm.
- R10: Synchronous reset clears all thresholds and the configuration to 0, deasserts the alarm (`alarm_n`=1, `alarm_flag`=0) and clears the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| time_flat | input | 56 | Current time fields, field i at bits [8i+7:8i] |
| alarm_n | output | 1 | Alarm output, active low, registered |
| alarm_flag | output | 1 | Alarm state, active high, registered |

## Verification
The hardest case to reach is the edge on which a fresh match start meets a clearing access. A close second is a match that keeps holding across a clear. Random field values would almost never line up with the thresholds. The stimulus therefore draws thresholds and time fields from a four-value range, and half the time it copies each threshold straight into its field. Matches and overlaps with bus accesses then happen often. Directed sequences first hold a match through a clear, then step the field away and back, and then line up a match start with a threshold read on the same edge.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int FIELD_W     = 8;
  localparam int NUM_FIELDS  = 7;
  localparam int ADDR_W      = 8;
  localparam int THR_WR_BASE = 'h80;
  localparam int THR_RD_BASE = 'h81;
  localparam int CFG_WR_ADDR = 'h94;
  localparam int CFG_RD_ADDR = 'h95;
  localparam int TIME_RD_BASE = 'hA1;

  typedef enum int {
    FLD_SEC   = 0,
    FLD_MIN   = 1,
    FLD_HOUR  = 2,
    FLD_DATE  = 3,
    FLD_MONTH = 4,
    FLD_DAY   = 5,
    FLD_YEAR  = 6
  } field_e;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int FW = FIELD_W,
  parameter int AW = ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [FW-1:0]    wdata,
  input  logic [NF*FW-1:0] time_flat,
  input  logic             alarm_q,
  output logic [NF*FW-1:0] thr_flat,
  output logic [FW-1:0]    cfg_q,
  output logic [FW-1:0]    rdata,
  output logic             acc_hit
);
  localparam logic [FW-1:0] CFG_MASK = FW'((1 << NF) - 1);
  localparam int            MIN_IDX  = int'(FLD_MIN);

  logic [FW-1:0] thr_q [NF];
  logic [FW-1:0] rd_val;
  logic          thr_range;

  genvar gi;
  generate
    for (gi = 0; gi < NF; gi++) begin : g_thr
      always_ff @(posedge clk) begin
        if (rst) begin
          thr_q[gi] <= '0;
        end else if (wr && addr == AW'(THR_WR_BASE + 2 * gi)) begin
          thr_q[gi] <= wdata;
        end
      end
      assign thr_flat[gi*FW +: FW] = thr_q[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr && addr == AW'(CFG_WR_ADDR)) begin
      cfg_q <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr == AW'(CFG_RD_ADDR)) begin
      rd_val = cfg_q & CFG_MASK;
    end
    for (int i = 0; i < NF; i++) begin
      if (addr == AW'(THR_RD_BASE + 2 * i)) begin
        rd_val = thr_q[i];
      end
      if (addr == AW'(TIME_RD_BASE + 2 * i)) begin
        if (i == MIN_IDX) begin
          rd_val = {alarm_q, time_flat[i*FW +: FW-1]};
        end else begin
          rd_val = time_flat[i*FW +: FW];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd ? rd_val : '0;
    end
  end

  always_comb begin
    thr_range = (addr >= AW'(THR_WR_BASE)) && (addr < AW'(THR_WR_BASE + 2 * NF));
    acc_hit   = (wr || rd) &&
                (thr_range || addr == AW'(CFG_WR_ADDR) || addr == AW'(CFG_RD_ADDR));
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int NF = 7,
  parameter int FW = 8
) (
  input  logic [NF*FW-1:0] time_flat,
  input  logic [NF*FW-1:0] thr_flat,
  input  logic [NF-1:0]    enable,
  output logic             match_now
);
  logic [NF-1:0] field_ok;

  genvar gi;
  generate
    for (gi = 0; gi < NF; gi++) begin : g_cmp
      assign field_ok[gi] = !enable[gi] ||
                            (time_flat[gi*FW +: FW] == thr_flat[gi*FW +: FW]);
    end
  endgenerate

  assign match_now = (|enable) && (&field_ok);
endmodule

// File: rtl/rtc_alarm_latch.sv
module rtc_alarm_latch (
  input  logic clk,
  input  logic rst,
  input  logic match_now,
  input  logic acc_hit,
  output logic match_q,
  output logic set_pulse,
  output logic alarm_q,
  output logic alarm_n
);
  logic alarm_nx;

  always_comb begin
    set_pulse = match_now && !match_q;
    alarm_nx  = set_pulse || (alarm_q && !acc_hit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= 1'b0;
      alarm_q <= 1'b0;
      alarm_n <= 1'b1;
    end else begin
      match_q <= match_now;
      alarm_q <= alarm_nx;
      alarm_n <= !alarm_nx;
    end
  end
endmodule

// File: rtl/rtc_alarm_top.sv
module rtc_alarm_top
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int FW = FIELD_W,
  parameter int AW = ADDR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [FW-1:0]    bus_wdata,
  output logic [FW-1:0]    bus_rdata,
  input  logic [NF*FW-1:0] time_flat,
  output logic             alarm_n,
  output logic             alarm_flag
);
  logic [NF*FW-1:0] thr_flat;
  logic [FW-1:0]    cfg_q;
  logic             acc_hit;
  logic             match_now;
  logic             match_q;
  logic             set_pulse;
  logic             alarm_q;

  rtc_alarm_regs #(.NF(NF), .FW(FW), .AW(AW)) regs_i (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .time_flat(time_flat), .alarm_q(alarm_q),
    .thr_flat(thr_flat), .cfg_q(cfg_q), .rdata(bus_rdata), .acc_hit(acc_hit)
  );

  rtc_alarm_match #(.NF(NF), .FW(FW)) match_i (
    .time_flat(time_flat), .thr_flat(thr_flat), .enable(cfg_q[NF-1:0]),
    .match_now(match_now)
  );

  rtc_alarm_latch latch_i (
    .clk(clk), .rst(rst), .match_now(match_now), .acc_hit(acc_hit),
    .match_q(match_q), .set_pulse(set_pulse), .alarm_q(alarm_q),
    .alarm_n(alarm_n)
  );

  assign alarm_flag = alarm_q;
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk #(
  parameter int NF = 7,
  parameter int FW = 8,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic [FW-1:0] bus_rdata,
  input logic          alarm_n,
  input logic          alarm_flag,
  input logic          match_now,
  input logic          match_q,
  input logic          set_pulse,
  input logic          acc_hit,
  input logic [FW-1:0] cfg_q
);
  // R10
  reset_idle_chk: assert property (@(posedge clk) rst |=> (alarm_n && !alarm_flag && bus_rdata == '0));

  // R3
  cfg_zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!alarm_flag && cfg_q[NF-1:0] == '0) |=> !alarm_flag);

  // R2
  set_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_flag) |-> $past(match_now));

  // R4
  no_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
    (!alarm_flag && match_q) |=> !alarm_flag);

  // R5
  hold_until_access_chk: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag && !acc_hit) |=> alarm_flag);

  // R5
  access_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag && acc_hit && !set_pulse) |=> !alarm_flag);

  // R1
  cfg_top_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == AW'('h95)) |=> !bus_rdata[FW-1]);
endmodule

bind rtc_alarm_top rtc_alarm_chk #(.NF(NF), .FW(FW), .AW(AW)) chk_i (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .alarm_n(alarm_n), .alarm_flag(alarm_flag),
  .match_now(match_now), .match_q(match_q), .set_pulse(set_pulse),
  .acc_hit(acc_hit), .cfg_q(cfg_q)
);

// File: tb/rtc_alarm_top_tb_top.sv
module rtc_alarm_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 7;
  localparam int FW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NF*FW-1:0] time_flat = '0;
  logic          alarm_n;
  logic          alarm_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] t [NF];
  logic [7:0] m_thr [NF];
  logic [6:0] m_cfg;
  logic       m_alarm;
  logic       m_mprev;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_top dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .time_flat(time_flat),
    .alarm_n(alarm_n), .alarm_flag(alarm_flag)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NF*FW-1:0] pack_time();
    logic [NF*FW-1:0] v;
    for (int i = 0; i < NF; i++) v[i*FW +: FW] = t[i];
    return v;
  endfunction

  function automatic logic model_match();
    logic ok = (m_cfg != 0);
    for (int i = 0; i < NF; i++)
      if (m_cfg[i] && t[i] != m_thr[i]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic is_alarm_addr(logic [7:0] a);
    return (a >= 8'h80 && a <= 8'h8D) || a == 8'h94 || a == 8'h95;
  endfunction

  function automatic logic [7:0] exp_read(logic [7:0] a);
    logic [7:0] v = 8'h00;
    if (a == 8'h95) v = {1'b0, m_cfg};
    for (int i = 0; i < NF; i++) begin
      if (a == 8'(8'h81 + 2 * i)) v = m_thr[i];
      if (a == 8'(8'hA1 + 2 * i)) v = (i == 1) ? {m_alarm, t[i][6:0]} : t[i];
    end
    return v;
  endfunction

  task automatic cyc(string tag, logic [7:0] a, logic w, logic r, logic [7:0] d);
    logic mn, acc;
    logic [7:0] er;
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    time_flat = pack_time();
    mn  = model_match();
    acc = (w || r) && is_alarm_addr(a);
    er  = r ? exp_read(a) : 8'h00;
    @(posedge clk);
    m_alarm = (mn && !m_mprev) || (m_alarm && !acc);
    m_mprev = mn;
    if (w) begin
      for (int i = 0; i < NF; i++)
        if (a == 8'(8'h80 + 2 * i)) m_thr[i] = d;
      if (a == 8'h94) m_cfg = d[6:0];
    end
    @(negedge clk);
    chk(tag, "alarm_n", 32'(alarm_n), 32'(!m_alarm));
    chk(tag, "alarm_flag", 32'(alarm_flag), 32'(m_alarm));
    chk(tag, "bus_rdata", 32'(bus_rdata), 32'(er));
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic idle(string tag, int n);
    for (int k = 0; k < n; k++) cyc(tag, 8'h00, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd7315));
    for (int i = 0; i < NF; i++) begin t[i] = 8'h00; m_thr[i] = 8'h00; end
    m_cfg = '0; m_alarm = 1'b0; m_mprev = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10", "alarm_n", 32'(alarm_n), 32'd1);
    chk("R10", "alarm_flag", 32'(alarm_flag), 32'd0);
    chk("R10", "bus_rdata", 32'(bus_rdata), 32'd0);
    cyc("R10", 8'h95, 1'b0, 1'b1, 8'h00);
    cyc("R10", 8'h8D, 1'b0, 1'b1, 8'h00);

    // R7, R8: threshold and config map, unmapped read
    cyc("R7", 8'h80, 1'b1, 1'b0, 8'h30);
    cyc("R7", 8'h81, 1'b0, 1'b1, 8'h00);
    cyc("R7", 8'h8C, 1'b1, 1'b0, 8'h24);
    cyc("R7", 8'h8D, 1'b0, 1'b1, 8'h00);
    cyc("R8", 8'h50, 1'b0, 1'b1, 8'h00);
    idle("R8", 1);
    // R1: bit 7 ignored and reads 0
    cyc("R1", 8'h94, 1'b1, 1'b0, 8'h80);
    cyc("R1", 8'h95, 1'b0, 1'b1, 8'h00);
    chk("R1", "cfg readback", 32'(bus_rdata), 32'h00);

    // R2: seconds only (once per minute)
    cyc("R2", 8'h94, 1'b1, 1'b0, 8'h01);
    t[0] = 8'h29; idle("R2", 2);
    t[0] = 8'h30; idle("R2", 1);
    chk("R2", "seconds alarm", 32'(alarm_n), 32'd0);
    // R9: minutes readback shows alarm, does not clear
    t[1] = 8'h45;
    cyc("R9", 8'hA3, 1'b0, 1'b1, 8'h00);
    chk("R9", "minutes bit7", 32'(bus_rdata), 32'hC5);
    cyc("R9", 8'hA1, 1'b0, 1'b1, 8'h00);
    chk("R9", "still set", 32'(alarm_flag), 32'd1);
    // R5: config read clears; R4: held match does not retrigger
    cyc("R5", 8'h95, 1'b0, 1'b1, 8'h00);
    chk("R5", "cleared", 32'(alarm_flag), 32'd0);
    idle("R4", 3);
    chk("R4", "no retrigger", 32'(alarm_flag), 32'd0);
    t[0] = 8'h31; idle("R4", 1);
    t[0] = 8'h30; idle("R4", 1);
    chk("R4", "retrigger", 32'(alarm_flag), 32'd1);
    // R6: match start and clearing access on one edge
    t[0] = 8'h31;
    cyc("R6", 8'h8B, 1'b0, 1'b1, 8'h00);
    t[0] = 8'h30;
    cyc("R6", 8'h81, 1'b0, 1'b1, 8'h00);
    chk("R6", "set wins", 32'(alarm_flag), 32'd1);
    cyc("R5", 8'h82, 1'b1, 1'b0, 8'h12);
    chk("R5", "threshold write clears", 32'(alarm_flag), 32'd0);

    // R2: minutes only (once per hour)
    cyc("R2", 8'h94, 1'b1, 1'b0, 8'h02);
    t[1] = 8'h11; idle("R2", 1);
    t[1] = 8'h12; idle("R2", 2);
    chk("R2", "minutes alarm", 32'(alarm_flag), 32'd1);
    cyc("R5", 8'h94, 1'b1, 1'b0, 8'h00);

    // R3: config 0 with all fields equal
    for (int i = 0; i < NF; i++) t[i] = m_thr[i];
    t[1] = 8'h00; t[0] = 8'h00;
    idle("R3", 3);
    for (int i = 0; i < NF; i++) t[i] = m_thr[i];
    idle("R3", 3);
    chk("R3", "config zero", 32'(alarm_flag), 32'd0);

    // R1: 0x4F ignores month/day
    for (int i = 0; i < NF; i++) t[i] = m_thr[i];
    t[4] = 8'h09; t[5] = 8'h03; t[6] = 8'h01;
    cyc("R1", 8'h94, 1'b1, 1'b0, 8'h4F);
    idle("R1", 1);
    t[6] = m_thr[6]; idle("R1", 1);
    chk("R1", "0x4F fires", 32'(alarm_flag), 32'd1);
    cyc("R5", 8'h95, 1'b0, 1'b1, 8'h00);
    // R1: month and day bits
    cyc("R1", 8'h94, 1'b1, 1'b0, 8'h30);
    idle("R1", 1);
    t[4] = m_thr[4]; t[5] = m_thr[5]; idle("R1", 2);
    chk("R1", "month/day fire", 32'(alarm_flag), 32'd1);

    // Random mix, model-checked
    for (int n = 0; n < 4000; n++) begin
      int unsigned act;
      logic [7:0] a;
      for (int i = 0; i < NF; i++)
        t[i] = ($urandom % 2 == 0) ? m_thr[i] : 8'($urandom % 4);
      act = $urandom % 20;
      if (act < 2) begin
        cyc("R2", 8'(8'h80 + 2 * ($urandom % NF)), 1'b1, 1'b0, 8'($urandom % 4));
      end else if (act < 3) begin
        cyc("R1", 8'h94, 1'b1, 1'b0, 8'($urandom));
      end else if (act < 5) begin
        a = 8'(8'h81 + 2 * ($urandom % NF));
        if ($urandom % 2 == 0) a = 8'(8'hA1 + 2 * ($urandom % NF));
        if ($urandom % 4 == 0) a = 8'h95;
        cyc("R5", a, 1'b0, 1'b1, 8'h00);
      end else begin
        cyc("R4", 8'h00, 1'b0, 1'b0, 8'h00);
      end
    end

    done = 1'b1;
    summary();
  end
endmodule